// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises bytes from a processor onto an asynchronous serial line. A timer outside the block supplies a one-cycle baud enable. A free-running counter divides that enable by a fixed oversampling factor of 16 to make a bit tick, and every serial bit lasts one tick period. The processor writes a byte with a one-cycle strobe. The byte lands in a holding register, and one clock later it moves into a frame shifter. The frame then leaves as a low start bit, the data bits least significant first, an optional parity bit and a high stop bit.

The holding register frees up as soon as its byte reaches the shifter. Software can therefore queue the next byte while the current frame is still on the line. A queued byte follows the stop bit with no idle time between frames. The completion pulse is raised only when the line actually goes quiet. The bit tick is never realigned by a write, so the delay from a write to its start bit depends on where the divider happens to be.

Top module: `uartTxDb`

## Requirements
- R1: After reset, `txd` is 1, `bufEmpty` is 1 and `txDone` is 0.
- R2: `bufEmpty` is 0 in the cycle after a write strobe. When the shifter is idle, the byte transfers on the next clock and `bufEmpty` returns to 1 one cycle later.
- R3: The start bit begins on a bit tick. With `baudEn` held high, the start bit appears on `txd` between 2 and 17 clocks after the clock edge that accepted the write.
- R4: A frame is a start bit of 0, then the data bits LSB first, then the parity bit if enabled, then a stop bit of 1. Each bit lasts 16 baud enables.
- R5: With `shortLen`=1 the frame carries 7 data bits and `wrData[7]` is not sent. With `shortLen`=0 it carries 8 data bits.
- R6: With `parEn`=1 a parity bit follows the data. With `parOdd`=0 the data bits plus the parity bit hold an even number of ones; with `parOdd`=1 they hold an odd number.
- R7: The bit-tick divider runs freely from reset and is never restarted by a write. Every start bit therefore begins on the same phase, modulo 16 baud enables, whatever the time of the write.
- R8: A byte written while a frame is shifting has its start bit begin exactly when the current stop bit ends, with no idle gap.
- R9: `txDone` is a one-cycle pulse at the end of a stop bit, raised only if no byte is waiting in the holding register. It is not raised between frames that are sent back to back.
- R10: A second write before the holding register has transferred its byte overwrites that byte. The overwritten byte is never sent.
- R11: `txd` stays high whenever no frame is in progress.
- R12: `shortLen`, `parEn` and `parOdd` are sampled when a byte moves into the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudEn | input | 1 | One-cycle baud enable from the external timer |
| wrStb | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to transmit |
| shortLen | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| parEn | input | 1 | 1 appends a parity bit |
| parOdd | input | 1 | 1 selects odd parity, 0 selects even |
| txd | output | 1 | Serial data out, idles high |
| bufEmpty | output | 1 | Holding register free for a new byte |
| txDone | output | 1 | One-cycle pulse when the line goes idle after a stop bit |

## Verification
Corruption in the frame shifter or in the bit counter shows on `txd` within one bit time, 16 baud enables, as a wrong data bit, a wrong parity bit or a stop bit that is missing or misplaced. A holding flag stuck in the wrong state shows on `bufEmpty` in the very next clock. It also shows one frame later, as a lost or duplicated byte, or as a `txDone` pulse between back-to-back frames. A divider that is wrongly reset by writes shows only as start-bit edges landing on different phases from frame to frame. The bench measures these phases against the clock count since reset.

// File: rtl/uartTxPkg.sv
package uartTxPkg;
  typedef struct packed {
    logic captureHold;
    logic loadFrame;
    logic sendStart;
    logic shiftBit;
  } txStrobes_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } txState_t;
endpackage

// File: rtl/baudDiv.sv
module baudDiv #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudEn,
  output logic tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (baudEn) divCnt <= (divCnt == LAST) ? '0 : divCnt + 1'b1;
  end

  assign tick = baudEn && (divCnt == LAST);
endmodule

// File: rtl/txControl.sv
module txControl
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrStb,
  input  logic       shortLen,
  input  logic       parEn,
  output txStrobes_t strobes,
  output logic       holdFull,
  output logic       busy,
  output logic       txDone
);
  localparam int CNT_W = $clog2(DATA_W + 3);

  txState_t   state;
  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] lenNow;
  logic       doneNext;

  // bits after the start bit: data + parity + stop
  assign lenNow = (shortLen ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W))
                + CNT_W'(parEn) + CNT_W'(1);

  always_comb begin
    strobes = '0;
    strobes.captureHold = wrStb;
    doneNext = 1'b0;
    unique case (state)
      TX_IDLE:  if (holdFull) strobes.loadFrame = 1'b1;
      TX_ARMED: if (tick) strobes.sendStart = 1'b1;
      TX_SEND: begin
        if (tick) begin
          if (bitsLeft != '0) strobes.shiftBit = 1'b1;
          else if (holdFull) begin
            strobes.loadFrame = 1'b1;
            strobes.sendStart = 1'b1;
          end else doneNext = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= TX_IDLE;
      holdFull <= 1'b0;
      bitsLeft <= '0;
      frameLen <= '0;
      txDone   <= 1'b0;
    end else begin
      txDone <= doneNext;
      if (wrStb) holdFull <= 1'b1;
      else if (strobes.loadFrame) holdFull <= 1'b0;
      if (strobes.loadFrame) frameLen <= lenNow;
      if (strobes.sendStart) bitsLeft <= strobes.loadFrame ? lenNow : frameLen;
      else if (strobes.shiftBit) bitsLeft <= bitsLeft - 1'b1;
      unique case (state)
        TX_IDLE:  if (strobes.loadFrame) state <= TX_ARMED;
        TX_ARMED: if (strobes.sendStart) state <= TX_SEND;
        TX_SEND:  if (doneNext) state <= TX_IDLE;
        default:  state <= TX_IDLE;
      endcase
    end
  end

  assign busy = (state != TX_IDLE);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_SEND && !tick) |=> (state == TX_SEND));

  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !$past(holdFull));
endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shortLen,
  input  logic              parEn,
  input  logic              parOdd,
  output logic              txd
);
  localparam int FR_W = DATA_W + 2;

  logic [DATA_W-1:0] holdReg;
  logic [FR_W-1:0]   frameReg;
  logic [FR_W-1:0]   built;
  logic [DATA_W-1:0] masked;
  logic              parBit;

  always_comb begin
    masked = holdReg;
    if (shortLen) masked[DATA_W-1] = 1'b0;
    parBit = (^masked) ^ parOdd;
    built = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || !shortLen) built[i] = masked[i];
    end
    if (parEn) begin
      if (shortLen) built[DATA_W-1] = parBit;
      else built[DATA_W] = parBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      frameReg <= '1;
      txd      <= 1'b1;
    end else begin
      if (strobes.captureHold) holdReg <= wrData;
      if (strobes.loadFrame) frameReg <= built;
      else if (strobes.shiftBit) frameReg <= {1'b1, frameReg[FR_W-1:1]};
      if (strobes.sendStart) txd <= 1'b0;
      else if (strobes.shiftBit) txd <= frameReg[0];
    end
  end

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sendStart |=> !txd);
endmodule

// File: rtl/uartTxDb.sv
module uartTxDb
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudEn,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shortLen,
  input  logic              parEn,
  input  logic              parOdd,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txDone
);
  txStrobes_t strobes;
  logic tick;
  logic holdFull;
  logic busy;

  baudDiv #(.DIV(DIV)) uDiv (
    .clk(clk), .rstN(rstN), .baudEn(baudEn), .tick(tick)
  );

  txControl #(.DATA_W(DATA_W)) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrStb(wrStb),
    .shortLen(shortLen), .parEn(parEn), .strobes(strobes),
    .holdFull(holdFull), .busy(busy), .txDone(txDone)
  );

  txDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .shortLen(shortLen), .parEn(parEn), .parOdd(parOdd), .txd(txd)
  );

  assign bufEmpty = !holdFull;

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  // R3
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txd) |-> $past(tick));

  // R9
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txd);
endmodule

// File: tb/tb_uartTxDb.sv
module tb_uartTxDb;
  logic clk = 0;
  logic rstN = 0;
  logic baudEn = 1;
  logic wrStb = 0;
  logic [7:0] wrData = '0;
  logic shortLen = 0, parEn = 0, parOdd = 0;
  logic txd, bufEmpty, txDone;

  int total = 0, failed = 0, cyc = 0, doneCnt = 0, wideDone = 0, wEdge = 0;
  int phase0 = -1;
  logic prevDone = 0;
  bit finished = 0;

  uartTxDb dut (
    .clk(clk), .rstN(rstN), .baudEn(baudEn), .wrStb(wrStb), .wrData(wrData),
    .shortLen(shortLen), .parEn(parEn), .parOdd(parOdd),
    .txd(txd), .bufEmpty(bufEmpty), .txDone(txDone)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (txDone) doneCnt++;
    if (txDone && prevDone) wideDone++;
    prevDone = txDone;
  end

  // {shortLen, parEn, parOdd, data}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h55}, {3'b010, 8'hA3}, {3'b011, 8'hA3}, {3'b100, 8'hFF},
    {3'b110, 8'h81}, {3'b111, 8'h7E}, {3'b000, 8'h00}, {3'b011, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrData = d; wrStb = 1;
    @(negedge clk); wrStb = 0; wEdge = cyc;
    chk(bufEmpty == 0, "R2 empty low after write", bufEmpty, 0);
    @(negedge clk);
    chk(bufEmpty == 1, "R2 empty back after transfer", bufEmpty, 1);
  endtask

  task automatic writeRaw(input logic [7:0] d);
    @(negedge clk); wrData = d; wrStb = 1;
    @(negedge clk); wrStb = 0;
  endtask

  task automatic recvFrame(input logic [7:0] d, input logic sl, pe, po,
                           input string tag, output int startCyc);
    int w = 0;
    int n = sl ? 7 : 8;
    logic [7:0] m = sl ? (d & 8'h7F) : d;
    while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    chk(w < 400, {tag, " R4 start seen"}, w, 0);
    startCyc = cyc;
    repeat (8) @(negedge clk);
    chk(txd == 0, {tag, " R4 start bit"}, txd, 0);
    for (int i = 0; i < n; i++) begin
      repeat (16) @(negedge clk);
      chk(txd == m[i], {tag, " R4 R5 data bit"}, txd, m[i]);
    end
    if (pe) begin
      repeat (16) @(negedge clk);
      chk(txd == ((^m) ^ po), {tag, " R6 parity bit"}, txd, (^m) ^ po);
    end
    repeat (16) @(negedge clk);
    chk(txd == 1, {tag, " R4 stop bit"}, txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int s1, s2, prevDoneCnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(txd == 1, "R1 txd idle", txd, 1);
    chk(bufEmpty == 1, "R1 bufEmpty", bufEmpty, 1);
    chk(txDone == 0, "R1 txDone", txDone, 0);

    for (int i = 0; i < 8; i++) begin
      {shortLen, parEn, parOdd} = VEC[i][10:8];
      repeat (i * 5 + 1) @(negedge clk);
      prevDoneCnt = doneCnt;
      writeByte(VEC[i][7:0]);
      recvFrame(VEC[i][7:0], VEC[i][10], VEC[i][9], VEC[i][8], "vec", s1);
      chk(s1 - wEdge >= 2 && s1 - wEdge <= 17, "R3 start latency", s1 - wEdge, 2);
      if (phase0 < 0) phase0 = s1 % 16;
      chk(s1 % 16 == phase0, "R7 start phase", s1 % 16, phase0);
      repeat (12) @(negedge clk);
      chk(doneCnt == prevDoneCnt + 1, "R9 done after frame", doneCnt, prevDoneCnt + 1);
      chk(txd == 1, "R11 idle high", txd, 1);
    end

    // R8 R9 R10: queued bytes, overwrite, no gap, single done
    shortLen = 0; parEn = 0; parOdd = 0;
    prevDoneCnt = doneCnt;
    writeByte(8'h3C);
    fork
      begin
        recvFrame(8'h3C, 0, 0, 0, "b2b first", s1);
        chk(doneCnt == prevDoneCnt, "R9 no done between frames", doneCnt, prevDoneCnt);
        recvFrame(8'hE7, 0, 0, 0, "b2b second R10", s2);
      end
      begin
        repeat (40) @(negedge clk);
        writeRaw(8'h99);
        repeat (3) @(negedge clk);
        writeRaw(8'hE7);
      end
    join
    chk(s2 - s1 == 160, "R8 back-to-back spacing", s2 - s1, 160);
    repeat (12) @(negedge clk);
    chk(doneCnt == prevDoneCnt + 1, "R9 R10 single done", doneCnt, prevDoneCnt + 1);
    chk(wideDone == 0, "R9 done one cycle", wideDone, 0);

    // R12: controls change mid-frame
    writeByte(8'hC5);
    @(negedge clk); shortLen = 1; parEn = 1; parOdd = 1;
    recvFrame(8'hC5, 0, 0, 0, "R12 latched controls", s1);
    repeat (12) @(negedge clk);
    chk(txd == 1, "R11 R12 idle after", txd, 1);
    chk(s1 % 16 == phase0, "R7 phase directed", s1 % 16, phase0);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule